// File: doc/BRIEF.md
# Per-CPU Interrupt Wakeup Generator

This block sits in an always-on domain beside a generic interrupt controller. It takes 128 shared peripheral interrupt lines and hands them to the interrupt controller unchanged, whatever the enable state. It also keeps, for each of two CPUs, a bank of four 32-bit enable words. Each CPU gets one wakeup request output. That output rises when any line that is active is also enabled in that CPU's bank, so a CPU in a low-power state can be brought back by an external interrupt.

Software reaches the enable words through a simple read/write bus inside a 4 KB window. The bus has a valid strobe and a write enable. A write takes effect at the clock edge that accepts it. Read data follows one cycle later, marked by a response-valid pulse. Enable bits reset to zero, so no wakeup is possible until software opens some lines.

Top module: `wkgen_top`

## Requirements
- R1: `irq_out` equals `irq_in` at all times, independent of any enable bit and of reset.
- R2: After reset, every enable bit is zero, `wake_req` is 0 and `bus_rvalid` is 0.
- R3: CPU c's enable word w (w = 0..3) sits at byte address 0x400*c + 4*w. Interrupt line n is controlled by bit n mod 32 of word n>>5.
- R4: `wake_req[c]` is 1 in the cycle after a clock edge at which any line is both active and enabled in CPU c's bank, and 0 otherwise (one register stage).
- R5: A write to one CPU's bank leaves the other CPU's bank unchanged, and each CPU's wake output depends only on its own bank.
- R6: A read accepted at a clock edge (`bus_valid`=1, `bus_we`=0) gives `bus_rvalid`=1 and the addressed word's current contents on `bus_rdata` in the following cycle. `bus_rvalid` is 0 in every other cycle.
- R7: An address is unmapped if its two low bits are nonzero, its word index (bits 9:2) is 4 or more, or its CPU field (bits 11:10) is 2 or more. Unmapped addresses read as zero, and writes to them change no enable word.
- R8: A bank whose four words are all zeros yields no wakeup even with all 128 lines active. All ones enables every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 128 | Incoming shared interrupt lines |
| irq_out | output | 128 | Lines forwarded to the interrupt controller |
| wake_req | output | 2 | Registered wakeup request, one bit per CPU |
| bus_valid | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read response strobe, one cycle after the read |

## Verification
The wake logic is driven with single active lines chosen to hit the lowest and highest bit of several words. The bank contents differ per CPU, so a swapped CPU index, a wrong word index or a wrong bit position each give a distinct wake pattern. All-lines-active against an all-zero bank separates a real mask from a stuck output. A single line against an all-ones bank shows that every bit is enabled. Bus write/read-back rows cover both banks, and misaligned, out-of-range-word and out-of-range-CPU writes are followed by reads of the words they could alias onto.

// File: rtl/wkgen_pkg.sv
package wkgen_pkg;
  localparam int NUM_LINES  = 128;
  localparam int WORD_W     = 32;
  localparam int NUM_CPU    = 2;
  localparam int ADDR_W     = 12;
  localparam int BANK_SHIFT = 10;                 // 0x400 bank stride
  localparam int WORDS      = NUM_LINES / WORD_W;
  localparam int WIDX_W     = $clog2(WORDS);
  localparam int CPU_IDX_W  = ADDR_W - BANK_SHIFT;

  typedef struct packed {
    logic                 hit;
    logic [CPU_IDX_W-1:0] cpu;
    logic [WIDX_W-1:0]    word;
  } dec_t;

  // line n -> enable word index
  function automatic int unsigned line_word(input int unsigned n);
    return n / WORD_W;
  endfunction

  // line n -> bit within its enable word
  function automatic int unsigned line_bit(input int unsigned n);
    return n % WORD_W;
  endfunction

  // byte address -> bank / word, with the mapped check
  function automatic dec_t decode(input logic [ADDR_W-1:0] a);
    dec_t d;
    d.cpu  = a[BANK_SHIFT +: CPU_IDX_W];
    d.word = a[2 +: WIDX_W];
    d.hit  = (a[1:0] == 2'b00) &&
             (int'(a[BANK_SHIFT-1:2]) < WORDS) &&
             (int'(a[ADDR_W-1:BANK_SHIFT]) < NUM_CPU);
    return d;
  endfunction
endpackage

// File: rtl/wkgen_regbank.sv
module wkgen_regbank #(
  parameter int WORD_W = wkgen_pkg::WORD_W,
  parameter int WORDS  = wkgen_pkg::WORDS,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int BITS   = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_data,
  output logic [BITS-1:0]   en_flat
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    logic word_sel;
    assign word_sel = wr_en && (wr_word == WIDX_W'(w));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_flat[w*WORD_W +: WORD_W] <= '0;
      else if (word_sel) en_flat[w*WORD_W +: WORD_W] <= wr_data;
    end
  end

  // R5: a bank that is not selected keeps its contents
  a_r5_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(en_flat));
endmodule

// File: rtl/wkgen_wake_reduce.sv
module wkgen_wake_reduce #(
  parameter int LINES = wkgen_pkg::NUM_LINES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq,
  input  logic [LINES-1:0] en,
  output logic             wake
);
  logic [LINES-1:0] hits;
  logic             any_hit;

  assign hits    = irq & en;
  assign any_hit = |hits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake <= 1'b0;
    else        wake <= any_hit;
  end

  // R4: wake follows enabled activity after one register stage
  a_r4_wake_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(irq & en)) |=> wake);
  a_r4_wake_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(irq & en)) |=> !wake);
endmodule

// File: rtl/wkgen_top.sv
module wkgen_top
  import wkgen_pkg::*;
#(
  parameter int LINES  = NUM_LINES,
  parameter int NCPU   = NUM_CPU,
  parameter int AW     = ADDR_W,
  parameter int DW     = WORD_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] irq_in,
  output logic [LINES-1:0] irq_out,
  output logic [NCPU-1:0]  wake_req,
  input  logic             bus_valid,
  input  logic             bus_we,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata,
  output logic             bus_rvalid
);
  localparam int NWORDS = LINES / DW;

  // R1: straight pass-through to the interrupt controller
  assign irq_out = irq_in;

  dec_t              dec;
  logic              wr_fire;
  logic              rd_fire;
  logic [LINES-1:0]  en_all [NCPU];
  logic [DW-1:0]     rd_word;

  assign dec     = decode(bus_addr);
  assign wr_fire = bus_valid && bus_we && dec.hit;
  assign rd_fire = bus_valid && !bus_we;

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic bank_wr;
    assign bank_wr = wr_fire && (dec.cpu == CPU_IDX_W'(c));

    wkgen_regbank #(.WORD_W(DW), .WORDS(NWORDS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (bank_wr),
      .wr_word (dec.word),
      .wr_data (bus_wdata),
      .en_flat (en_all[c])
    );

    wkgen_wake_reduce #(.LINES(LINES)) u_wake (
      .clk   (clk),
      .rst_n (rst_n),
      .irq   (irq_in),
      .en    (en_all[c]),
      .wake  (wake_req[c])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int c = 0; c < NCPU; c++) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (dec.hit && dec.cpu == CPU_IDX_W'(c) && dec.word == WIDX_W'(w))
          rd_word = en_all[c][w*DW +: DW];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= rd_fire;
      bus_rdata  <= rd_fire ? rd_word : '0;
    end
  end

  // R6: read response one cycle after each accepted read, never otherwise
  a_r6_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> bus_rvalid);
  a_r6_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !bus_rvalid);
  // R7: reads of unmapped offsets return zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && !dec.hit) |=> (bus_rdata == '0));
endmodule

// File: tb/tb_wkgen_top.sv
`timescale 1ns/1ps
module tb_wkgen_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] irq_in = '0;
  logic [127:0] irq_out;
  logic [1:0]   wake_req;
  logic         bus_valid = 1'b0;
  logic         bus_we = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic         bus_rvalid;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  wkgen_top dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
    .wake_req(wake_req), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid)
  );

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    bus_valid = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  // One line active; wake checked after one register stage (R4)
  task automatic wake_line(input int n, input logic [1:0] exp, input string req);
    @(negedge clk);
    irq_in = '0; irq_in[n] = 1'b1;
    check("R4 wake before edge", {126'b0, wake_req}, 128'b0);
    @(negedge clk);
    check(req, {126'b0, wake_req}, {126'b0, exp});
    irq_in = '0;
    @(negedge clk);
    check("R4 wake drops", {126'b0, wake_req}, 128'b0);
  endtask

  // {waddr, wdata, raddr, expected, requirement number}
  localparam logic [95:0] TBL [12] = '{
    {12'h000, 32'hA5A5A5A5, 12'h000, 32'hA5A5A5A5, 8'd3}, // R3 cpu0 w0
    {12'h004, 32'h12345678, 12'h004, 32'h12345678, 8'd3}, // R3 cpu0 w1
    {12'h008, 32'hFFFFFFFF, 12'h008, 32'hFFFFFFFF, 8'd3}, // R3 cpu0 w2
    {12'h00C, 32'h80000001, 12'h00C, 32'h80000001, 8'd3}, // R3 cpu0 w3
    {12'h400, 32'h0F0F0F0F, 12'h400, 32'h0F0F0F0F, 8'd3}, // R3 cpu1 w0
    {12'h40C, 32'hDEADBEEF, 12'h40C, 32'hDEADBEEF, 8'd3}, // R3 cpu1 w3
    {12'h404, 32'h00000000, 12'h000, 32'hA5A5A5A5, 8'd5}, // R5 other bank intact
    {12'h010, 32'hFFFFFFFF, 12'h010, 32'h00000000, 8'd7}, // R7 word 4 reads zero
    {12'h800, 32'hFFFFFFFF, 12'h000, 32'hA5A5A5A5, 8'd7}, // R7 cpu 2 no alias
    {12'h002, 32'hFFFFFFFF, 12'h000, 32'hA5A5A5A5, 8'd7}, // R7 misaligned ignored
    {12'h41C, 32'h11111111, 12'h40C, 32'hDEADBEEF, 8'd7}, // R7 word 7 ignored
    {12'hC00, 32'h00000001, 12'hC00, 32'h00000000, 8'd7}  // R7 cpu 3 reads zero
  };

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        rv;
    logic [127:0] pat;

    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 wake in reset", {126'b0, wake_req}, 128'b0);
    check("R2 rvalid in reset", {127'b0, bus_rvalid}, 128'b0);
    irq_in = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    #1 check("R1 passthru in reset", irq_out, irq_in);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 no wake with zero enables", {126'b0, wake_req}, 128'b0);
    irq_in = '0;
    for (int a = 0; a < 4; a++) begin
      bus_read(12'(a * 4), rd, rv);
      check("R2 enable word reset", {96'b0, rd}, 128'b0);
    end
    @(negedge clk);
    check("R6 rvalid single pulse", {127'b0, bus_rvalid}, 128'b0);

    for (int i = 0; i < 12; i++) begin
      bus_write(TBL[i][95:84], TBL[i][83:52]);
      bus_read(TBL[i][51:40], rd, rv);
      check($sformatf("R6 rvalid row %0d", i), {127'b0, rv}, 128'd1);
      check($sformatf("R%0d readback row %0d", TBL[i][7:0], i),
            {96'b0, rd}, {96'b0, TBL[i][39:8]});
    end

    // R4 / R3 / R5 line mapping: cpu0 {A5A5A5A5,12345678,FFFFFFFF,80000001}
    // cpu1 {0F0F0F0F,00000000,00000000,DEADBEEF}
    wake_line(0,   2'b11, "R3 line 0");
    wake_line(1,   2'b10, "R5 line 1 cpu1 only");
    wake_line(32,  2'b00, "R3 line 32");
    wake_line(35,  2'b01, "R3 line 35");
    wake_line(64,  2'b01, "R5 line 64 cpu0 only");
    wake_line(96,  2'b11, "R3 line 96");
    wake_line(100, 2'b00, "R3 line 100");
    wake_line(127, 2'b11, "R3 line 127");

    // R8: all-zero bank masks everything
    for (int w = 0; w < 4; w++) bus_write(12'(12'h400 + w * 4), 32'h0);
    @(negedge clk);
    irq_in = '1;
    @(negedge clk);
    check("R8 zero bank masks all", {126'b0, wake_req}, 128'd1);
    check("R1 passthru all ones", irq_out, {128{1'b1}});
    irq_in = '0;
    // R8: all-ones bank enables every line
    for (int w = 0; w < 4; w++) bus_write(12'(12'h400 + w * 4), 32'hFFFFFFFF);
    wake_line(33,  2'b10, "R8 ones bank line 33");
    wake_line(101, 2'b10, "R8 ones bank line 101");

    // R1: pass-through with enables set
    pat = 128'hDEAD_0000_BEEF_1111_CAFE_2222_F00D_3333;
    @(negedge clk);
    irq_in = pat;
    #1 check("R1 passthru pattern", irq_out, pat);
    irq_in = '0;
    @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule